// File: doc/BRIEF.md
# Card Presence Debounce and Host Interrupt

This block watches the mechanical card-detect switch of a smart-card slot, together with two supply-health flags. It filters the switch so that contact bounce cannot reach the host, and it interprets the filtered level through a programmable switch polarity. An accepted insertion or removal raises an interrupt request toward the host. A falling battery-OK or converter-OK flag raises the same request. The interrupt is an open-drain style pull-down enable. The host releases it by deselecting the device, which is a rising edge on the active-low select, or by a rising edge on the power-enable input.

One status output serves several conditions. While the program-select input is high, the two address inputs choose what the status output shows: card presence, battery state, converter state, or the programmed polarity. While program-select is low, the status output keeps its last value. The same select and address inputs are used to program the switch polarity, together with a data bit.

All asynchronous inputs pass through synchronizers before they are used. The filter window is given in microseconds and converted into clock cycles from a clock-frequency parameter.

Top module: `card_sense_irq`

## Requirements
- R1: After reset, int_pull_o is 0 (interrupt released), status_o is 0, and the polarity is normally-open.
- R2: A change of the synchronized card-detect level becomes the filtered level only after it has held for DEB_CYCLES consecutive clocks (CLK_KHZ*DEBOUNCE_US/1000). This applies to both rising and falling changes. A change that reverts earlier is discarded, and the count starts again.
- R3: With normally-open polarity (polarity bit 0), a card is present when the filtered detect level is low.
- R4: A rising edge on cs_ni, with prog_sel_i low and addr_i = 2'b11, loads data_i into the polarity bit. Value 1 selects normally-closed, where a card is present when the filtered level is high. A polarity change alone does not assert the interrupt.
- R5: Each accepted insertion or removal sets int_pull_o to 1.
- R6: A falling edge on bat_ok_i or on conv_ok_i sets int_pull_o to 1.
- R7: A rising edge on cs_ni or on pwr_en_i clears int_pull_o to 0. A set in the same cycle takes priority over the clear.
- R8: With prog_sel_i high, status_o shows the source chosen by addr_i: 2'b00 selects card present (1 = present), 2'b01 selects battery OK, 2'b10 selects converter OK, and 2'b11 selects the polarity bit.
- R9: With prog_sel_i low, status_o does not change, whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| det_raw_i | input | 1 | Raw card-detect switch level (pulled high) |
| bat_ok_i | input | 1 | Battery supply healthy flag |
| conv_ok_i | input | 1 | Card-supply converter healthy flag |
| cs_ni | input | 1 | Host chip select, active low |
| pwr_en_i | input | 1 | Host power-enable request |
| prog_sel_i | input | 1 | 1 = status read, 0 = programming / status frozen |
| addr_i | input | 2 | Status source or programming target |
| data_i | input | 1 | Programming data bit |
| int_pull_o | output | 1 | 1 = pull interrupt line low |
| status_o | output | 1 | Multiplexed status bit |

## Verification
A filter counter that is stuck or miscounted shows up at status_o, with address 00 selected, one window after a card change. The presence bit then flips too early, after a short glitch, or not at all, and it also fails to raise int_pull_o. A lost interrupt flag, or one that cannot be cleared, shows at int_pull_o a few cycles after the triggering or clearing edge, once the synchronizer latency has passed. A wrong polarity bit becomes visible at once through address 11. It also inverts the presence reading.

// File: rtl/card_sense_pkg.sv
package card_sense_pkg;
  typedef enum logic [1:0] {
    SEL_CARD = 2'b00,
    SEL_BAT  = 2'b01,
    SEL_CONV = 2'b10,
    SEL_POL  = 2'b11
  } stat_sel_e;

  // synchronized input vector bit positions
  localparam int unsigned IN_DET  = 0;
  localparam int unsigned IN_BAT  = 1;
  localparam int unsigned IN_CONV = 2;
  localparam int unsigned IN_CSN  = 3;
  localparam int unsigned IN_PWR  = 4;
  localparam int unsigned IN_W    = 5;
  // idle levels: detect pulled up, supplies OK, deselected, power off
  localparam logic [IN_W-1:0] IN_IDLE = 5'b01111;
endpackage

// File: rtl/cs_sync.sv
module cs_sync #(
  parameter int unsigned W = 1,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg_q[s] <= RST_VAL;
      else if (s == 0) stg_q[s] <= d_i;
      else stg_q[s] <= stg_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/cs_debounce.sv
module cs_debounce #(
  parameter int unsigned DEB_CYCLES = 2500,
  parameter logic RST_LVL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic raw_i,
  output logic level_o,
  output logic evt_o
);
  localparam int unsigned CW = $clog2(DEB_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(DEB_CYCLES - 1);

  logic [CW-1:0] cnt_q;
  logic          level_q, evt_q;
  logic          accept;

  assign accept = (raw_i != level_q) && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      level_q <= RST_LVL;
      evt_q   <= 1'b0;
    end else begin
      evt_q <= accept;
      if (raw_i == level_q) begin
        cnt_q <= '0;  // reverted: restart window
      end else if (accept) begin
        cnt_q   <= '0;
        level_q <= raw_i;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign level_o = level_q;
  assign evt_o   = evt_q;

  a_r2_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (raw_i == level_q) |=> (cnt_q == '0));
  a_r2_full_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (level_q != $past(level_q)) |-> ($past(cnt_q) == LAST));
  a_r5_evt_marks_flip: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_q |-> (level_q != $past(level_q)));
endmodule

// File: rtl/cs_irq.sv
module cs_irq (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic card_evt_i,
  input  logic bat_ok_i,
  input  logic conv_ok_i,
  input  logic cs_n_i,
  input  logic pwr_en_i,
  output logic cs_rise_o,
  output logic int_o
);
  logic bat_q, conv_q, cs_q, pwr_q, int_q;
  logic set_irq, clr_irq;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bat_q  <= 1'b1;
      conv_q <= 1'b1;
      cs_q   <= 1'b1;
      pwr_q  <= 1'b0;
    end else begin
      bat_q  <= bat_ok_i;
      conv_q <= conv_ok_i;
      cs_q   <= cs_n_i;
      pwr_q  <= pwr_en_i;
    end
  end

  assign set_irq   = card_evt_i | (bat_q & ~bat_ok_i) | (conv_q & ~conv_ok_i);
  assign cs_rise_o = ~cs_q & cs_n_i;
  assign clr_irq   = cs_rise_o | (~pwr_q & pwr_en_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      int_q <= 1'b0;
    else if (set_irq) int_q <= 1'b1;  // set beats clear
    else if (clr_irq) int_q <= 1'b0;
  end

  assign int_o = int_q;

  a_r5_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    card_evt_i |=> int_q);
  a_r6_supply_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((bat_q && !bat_ok_i) || (conv_q && !conv_ok_i)) |=> int_q);
  a_r7_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_irq && !set_irq) |=> !int_q);
  a_r7_no_spurious: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(int_q) |-> $past(set_irq));
endmodule

// File: rtl/cs_status_mux.sv
module cs_status_mux
  import card_sense_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       prog_sel_i,
  input  logic [1:0] addr_i,
  input  logic       present_i,
  input  logic       bat_ok_i,
  input  logic       conv_ok_i,
  input  logic       pol_nc_i,
  output logic       status_o
);
  logic status_q, status_d;

  always_comb begin
    unique case (stat_sel_e'(addr_i))
      SEL_CARD: status_d = present_i;
      SEL_BAT:  status_d = bat_ok_i;
      SEL_CONV: status_d = conv_ok_i;
      SEL_POL:  status_d = pol_nc_i;
      default:  status_d = present_i;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         status_q <= 1'b0;
    else if (prog_sel_i) status_q <= status_d;
  end

  assign status_o = status_q;

  a_r9_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !prog_sel_i |=> $stable(status_q));
  a_r8_card_sel: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (prog_sel_i && addr_i == 2'b00) |=> (status_q == $past(present_i)));
endmodule

// File: rtl/card_sense_irq.sv
module card_sense_irq
  import card_sense_pkg::*;
#(
  parameter int unsigned CLK_KHZ     = 50000,
  parameter int unsigned DEBOUNCE_US = 50,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       det_raw_i,
  input  logic       bat_ok_i,
  input  logic       conv_ok_i,
  input  logic       cs_ni,
  input  logic       pwr_en_i,
  input  logic       prog_sel_i,
  input  logic [1:0] addr_i,
  input  logic       data_i,
  output logic       int_pull_o,
  output logic       status_o
);
  localparam int unsigned DEB_RAW    = (CLK_KHZ * DEBOUNCE_US) / 1000;
  localparam int unsigned DEB_CYCLES = (DEB_RAW < 2) ? 2 : DEB_RAW;

  logic [IN_W-1:0] in_raw, in_s;
  logic det_lvl, card_evt, cs_rise, pol_nc_q, present;

  assign in_raw[IN_DET]  = det_raw_i;
  assign in_raw[IN_BAT]  = bat_ok_i;
  assign in_raw[IN_CONV] = conv_ok_i;
  assign in_raw[IN_CSN]  = cs_ni;
  assign in_raw[IN_PWR]  = pwr_en_i;

  cs_sync #(.W(IN_W), .STAGES(SYNC_STAGES), .RST_VAL(IN_IDLE)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(in_raw), .q_o(in_s)
  );

  cs_debounce #(.DEB_CYCLES(DEB_CYCLES), .RST_LVL(IN_IDLE[IN_DET])) u_deb (
    .clk_i(clk_i), .rst_ni(rst_ni), .raw_i(in_s[IN_DET]),
    .level_o(det_lvl), .evt_o(card_evt)
  );

  cs_irq u_irq (
    .clk_i(clk_i), .rst_ni(rst_ni), .card_evt_i(card_evt),
    .bat_ok_i(in_s[IN_BAT]), .conv_ok_i(in_s[IN_CONV]),
    .cs_n_i(in_s[IN_CSN]), .pwr_en_i(in_s[IN_PWR]),
    .cs_rise_o(cs_rise), .int_o(int_pull_o)
  );

  // polarity write on deselect edge; select/address/data held by host
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pol_nc_q <= 1'b0;
    else if (cs_rise && !prog_sel_i && stat_sel_e'(addr_i) == SEL_POL)
      pol_nc_q <= data_i;
  end

  assign present = pol_nc_q ? det_lvl : ~det_lvl;

  cs_status_mux u_stat (
    .clk_i(clk_i), .rst_ni(rst_ni), .prog_sel_i(prog_sel_i), .addr_i(addr_i),
    .present_i(present), .bat_ok_i(in_s[IN_BAT]), .conv_ok_i(in_s[IN_CONV]),
    .pol_nc_i(pol_nc_q), .status_o(status_o)
  );

  a_r4_pol_only_on_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pol_nc_q != $past(pol_nc_q)) |-> $past(cs_rise && !prog_sel_i));
  a_r1_init_polarity: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> !pol_nc_q);
endmodule

// File: tb/card_sense_irq_tb.sv
module card_sense_irq_tb_top;
  localparam int unsigned DEB = 10;  // 200 kHz * 50 us

  logic clk = 1'b0, rst_n = 1'b0;
  logic det = 1'b1, bat = 1'b1, conv = 1'b1, cs_n = 1'b1, pwr = 1'b0;
  logic psel = 1'b1, dat = 1'b0;
  logic [1:0] addr = 2'b00;
  logic int_pull, status;
  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  card_sense_irq #(.CLK_KHZ(200), .DEBOUNCE_US(50)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .det_raw_i(det), .bat_ok_i(bat),
    .conv_ok_i(conv), .cs_ni(cs_n), .pwr_en_i(pwr), .prog_sel_i(psel),
    .addr_i(addr), .data_i(dat), .int_pull_o(int_pull), .status_o(status)
  );

  // addr, bat, conv, expected status
  localparam logic [4:0] VEC [6] = '{
    5'b01_1_1_1, 5'b10_1_1_1, 5'b01_0_1_0,
    5'b10_1_0_0, 5'b00_1_1_0, 5'b11_1_1_0
  };

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(logic got, logic exp, string req);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%0b exp=%0b", req, got, exp);
    end
  endtask

  task automatic cs_pulse();
    cs_n = 1'b0; tick(3); cs_n = 1'b1; tick(6);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    tick(3); rst_n = 1'b1; tick(3);
    chk(int_pull, 1'b0, "R1 int released");
    chk(status, 1'b0, "R1 status");

    for (int i = 0; i < 6; i++) begin
      addr = VEC[i][4:3]; bat = VEC[i][2]; conv = VEC[i][1];
      tick(6);
      chk(status, VEC[i][0], $sformatf("R8 vector %0d", i));
      if (i == 2) chk(int_pull, 1'b1, "R6 battery fall");
      if (i == 3) chk(int_pull, 1'b1, "R6 converter fall");
      bat = 1'b1; conv = 1'b1; tick(4);
      cs_pulse();
      chk(int_pull, 1'b0, "R7 cleared by cs rise");
    end
    addr = 2'b00; tick(2);
    chk(status, 1'b0, "R1 default normally-open reads absent");

    // insertion, normally-open: falling input
    det = 1'b0; tick(5);
    chk(status, 1'b0, "R2 not yet accepted");
    chk(int_pull, 1'b0, "R2 no early interrupt");
    tick(DEB + 4);
    chk(status, 1'b1, "R3 present on low");
    chk(int_pull, 1'b1, "R5 insertion interrupt");
    cs_pulse();
    chk(int_pull, 1'b0, "R7 cs clear");
    chk(status, 1'b1, "R7 clear keeps presence");

    // short glitch discarded
    det = 1'b1; tick(DEB - 3); det = 1'b0; tick(DEB + 6);
    chk(status, 1'b1, "R2 glitch rejected");
    chk(int_pull, 1'b0, "R2 glitch no interrupt");

    // removal, cleared by power-enable rise
    det = 1'b1; tick(DEB + 8);
    chk(status, 1'b0, "R2 removal accepted");
    chk(int_pull, 1'b1, "R5 removal interrupt");
    pwr = 1'b1; tick(6);
    chk(int_pull, 1'b0, "R7 pwr_en clear");

    // status frozen while prog_sel low
    psel = 1'b0; det = 1'b0; tick(DEB + 8);
    chk(status, 1'b0, "R9 frozen");
    chk(int_pull, 1'b1, "R5 insert while frozen");
    addr = 2'b01; bat = 1'b0; tick(6);
    chk(status, 1'b0, "R9 frozen on addr change");
    bat = 1'b1; addr = 2'b00; psel = 1'b1; tick(3);
    chk(status, 1'b1, "R9 resumes");
    det = 1'b1; tick(DEB + 8);
    cs_pulse();
    chk(int_pull, 1'b0, "R7 clear before polarity");

    // program normally-closed
    psel = 1'b0; addr = 2'b11; dat = 1'b1; cs_pulse();
    psel = 1'b1; tick(3);
    chk(status, 1'b1, "R4 polarity readback");
    addr = 2'b00; tick(3);
    chk(status, 1'b1, "R4 nc: high reads present");
    chk(int_pull, 1'b0, "R4 no interrupt from polarity change");
    det = 1'b0; tick(DEB + 8);
    chk(status, 1'b0, "R4 nc: low reads absent");
    chk(int_pull, 1'b1, "R5 nc removal interrupt");

    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end
endmodule